// File: doc/BRIEF.md
# Tone Gate and Refresh Toggle Control Port

This block is a small system control port placed beside an interval timer. Software writes one byte to it. Two bits of that byte matter. One bit drives the count-enable input of the timer channel that makes audio tones. The other bit enables the speaker: the speaker pin carries the tone channel's output ANDed with this enable. A tone of 896 Hz, for example, comes from running the tone channel as a square wave with divisor 1331 (0x0533) from a 1.1931817 MHz timer clock. This port only passes that waveform on.

A read returns four things: the two control bits as written, a status bit that toggles, and the live level of the tone channel's output. The status bit flips once on each rising edge of the refresh channel's output pulse. With the refresh channel dividing the 1.1931817 MHz timer clock by 18, the bit changes every 15.085 microseconds. Software counts these changes to measure delays, and the count does not depend on CPU speed.

All inputs are synchronous to `clk`. The read data is combinational from the port state and the live tone level.

Top module: `spk_sysctl_port`

## Requirements
- R1: When `wr_en` is high at a clock edge, bit 0 of `wr_data` is stored, and from that edge on it drives `tone_gate` (1 means the tone channel counts).
- R2: Bit 1 of `wr_data` is stored as the speaker enable. While reset is low, `spk_out` equals `tone_in` AND the stored enable, with no clock delay relative to `tone_in`.
- R3: Bits 0 and 1 of `rd_data` return the stored gate bit and the stored speaker enable.
- R4: Bit 5 of `rd_data` equals the live `tone_in` level at all times.
- R5: Bit 4 of `rd_data` is the toggle bit.
  - It inverts at the clock edge where `refresh_in` is first sampled high after having been sampled low.
  - It holds at every other edge, including while `refresh_in` stays high.
- R6: A write changes only bits 0 and 1. Written values in bits 2 through 7, including bit 4 and bit 5, are ignored. Bits 2, 3, 6 and 7 of `rd_data` always read 0.
- R7: When `wr_en` is low, the stored bits do not change, whatever `wr_data` holds.
- R8: While `rst` is high, `spk_out` is low. After reset, bits 0 and 1 read 0 and the toggle bit reads 0. A `refresh_in` that is already high when reset ends does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: bit 0 is the gate, bit 1 is the speaker enable |
| rd_data | output | 8 | Read byte: bits 0 and 1 are control, bit 4 is the toggle, bit 5 is the tone level |
| tone_in | input | 1 | Output level of the tone timer channel |
| refresh_in | input | 1 | Output pulse of the refresh timer channel |
| tone_gate | output | 1 | Count enable to the tone timer channel |
| spk_out | output | 1 | Gated speaker drive |

## Verification
A vector table writes each combination of gate and speaker enable against both tone levels. These cases separate a correct AND from an OR, a swapped pair of bits, or a registered tone path. Writes with all upper bits set, including bits 4 and 5, show whether read-only positions can be disturbed. Refresh pulses one cycle wide, a pulse held high for several cycles, and a refresh that is already high at reset release distinguish true edge detection from level sensing and from a spurious first edge. A write data change without `wr_en`, and `spk_out` checked during reset while the enable is still set, cover the hold and force-low rules.

// File: rtl/spk_port_pkg.sv
package spk_port_pkg;

    localparam int PORT_W   = 8;
    localparam int GATE_BIT = 0;
    localparam int SPK_BIT  = 1;
    localparam int TOG_BIT  = 4;
    localparam int TONE_BIT = 5;

    typedef struct packed {
        logic spk_en;
        logic gate;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [PORT_W-1:0] d);
        ctrl_t c;
        c.gate   = d[GATE_BIT];
        c.spk_en = d[SPK_BIT];
        return c;
    endfunction

    function automatic logic [PORT_W-1:0] pack_status(input ctrl_t c,
                                                      input logic tog,
                                                      input logic tone);
        logic [PORT_W-1:0] v;
        v           = '0;
        v[GATE_BIT] = c.gate;
        v[SPK_BIT]  = c.spk_en;
        v[TOG_BIT]  = tog;
        v[TONE_BIT] = tone;
        return v;
    endfunction

endpackage

// File: rtl/spk_ctrl_reg.sv
module spk_ctrl_reg
    import spk_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output ctrl_t        ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= decode_ctrl(wr_data);
        end
    end
endmodule

// File: rtl/spk_edge_toggle.sv
module spk_edge_toggle (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic tog_q
);
    logic prev_q;
    logic rise;

    assign rise = pulse_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= pulse_in;
            tog_q  <= 1'b0;
        end else begin
            prev_q <= pulse_in;
            if (rise) begin
                tog_q <= ~tog_q;
            end
        end
    end
endmodule

// File: rtl/spk_sysctl_port.sv
module spk_sysctl_port
    import spk_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         tone_in,
    input  logic         refresh_in,
    output logic         tone_gate,
    output logic         spk_out
);
    ctrl_t ctrl_q;
    logic  tog_q;

    spk_ctrl_reg #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    spk_edge_toggle u_tog (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (refresh_in),
        .tog_q    (tog_q)
    );

    assign tone_gate = ctrl_q.gate;
    assign spk_out   = tone_in & ctrl_q.spk_en & ~rst;
    assign rd_data   = pack_status(ctrl_q, tog_q, tone_in);
endmodule

// File: rtl/spk_sysctl_port_chk.sv
module spk_sysctl_port_chk
    import spk_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic         tone_in,
    input logic         refresh_in,
    input logic         tone_gate,
    input logic         spk_out
);
    AST_GATE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tone_gate == $past(wr_data[GATE_BIT]))); // R1

    AST_SPK_AND: assert property (@(posedge clk) disable iff (rst)
        spk_out == (tone_in & rd_data[SPK_BIT])); // R2

    AST_GATE_READBACK: assert property (@(posedge clk) disable iff (rst)
        rd_data[GATE_BIT] == tone_gate); // R3

    AST_TONE_LIVE: assert property (@(posedge clk) disable iff (rst)
        rd_data[TONE_BIT] == tone_in); // R4

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_in) |=> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT]))); // R5

    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(refresh_in) |=> $stable(rd_data[TOG_BIT])); // R5

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3:2] == 2'b00) && (rd_data[W-1:6] == '0)); // R6

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data[1:0])); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !spk_out); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (rd_data[1:0] == 2'b00) && !rd_data[TOG_BIT]); // R8
endmodule

bind spk_sysctl_port spk_sysctl_port_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .tone_in    (tone_in),
    .refresh_in (refresh_in),
    .tone_gate  (tone_gate),
    .spk_out    (spk_out)
);

// File: tb/tb_spk_sysctl_port.sv
module tb_spk_sysctl_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // {wr_data[18:11], tone[10], exp_gate[9], exp_spk[8], exp_rd[7:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {8'h03, 1'b1, 1'b1, 1'b1, 8'h23},
        {8'h03, 1'b0, 1'b1, 1'b0, 8'h03},
        {8'h01, 1'b1, 1'b1, 1'b0, 8'h21},
        {8'h02, 1'b1, 1'b0, 1'b1, 8'h22},
        {8'hFC, 1'b1, 1'b0, 1'b0, 8'h20},
        {8'hFF, 1'b0, 1'b1, 1'b0, 8'h03}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       tone_in;
    logic       refresh_in;
    logic       tone_gate;
    logic       spk_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spk_sysctl_port dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tone_in(tone_in), .refresh_in(refresh_in),
        .tone_gate(tone_gate), .spk_out(spk_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic refresh_pulse(input int hi_cycles);
        refresh_in = 1'b1;
        repeat (hi_cycles) @(negedge clk);
        refresh_in = 1'b0;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        tone_in = 1'b0; refresh_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 / R3: state after reset
        check("R8 rd after reset", rd_data, 8'h00);
        check("R1 gate after reset", {7'd0, tone_gate}, 8'h00);

        // Vector table: R1 R2 R3 R4 R6
        for (int i = 0; i < NVEC; i++) begin
            tone_in = VEC[i][10];
            do_write(VEC[i][18:11]);
            check("R1 tone_gate", {7'd0, tone_gate}, {7'd0, VEC[i][9]});
            check("R2 spk_out",   {7'd0, spk_out},   {7'd0, VEC[i][8]});
            check("R3/R4/R6 rd_data", rd_data, VEC[i][7:0]);
        end

        // R4: bit5 follows tone with no clock
        do_write(8'h03);
        tone_in = 1'b1; #1;
        check("R4 live tone high", rd_data, 8'h23);
        check("R2 spk combinational", {7'd0, spk_out}, 8'h01);
        tone_in = 1'b0; #1;
        check("R4 live tone low", rd_data, 8'h03);

        // R7: data without strobe ignored
        wr_data = 8'h00;
        repeat (3) @(negedge clk);
        check("R7 hold without wr_en", rd_data, 8'h03);

        // R5: toggle on single-cycle pulses
        refresh_pulse(1);
        check("R5 toggle after pulse 1", {7'd0, rd_data[4]}, 8'h01);
        repeat (17) @(negedge clk);
        check("R5 toggle holds between pulses", {7'd0, rd_data[4]}, 8'h01);
        refresh_pulse(1);
        check("R5 toggle after pulse 2", {7'd0, rd_data[4]}, 8'h00);
        repeat (17) @(negedge clk);
        // R5: long high pulse toggles once
        refresh_pulse(5);
        check("R5 long pulse single flip", {7'd0, rd_data[4]}, 8'h01);
        repeat (4) @(negedge clk);
        check("R5 steady after long pulse", {7'd0, rd_data[4]}, 8'h01);

        // R6: writing bit4 does not touch toggle
        do_write(8'h10);
        check("R6 bit4 write ignored", rd_data, 8'h10);
        do_write(8'h03);

        // R8: force low during reset while enable still set
        tone_in = 1'b1; #1;
        check("R2 spk before reset", {7'd0, spk_out}, 8'h01);
        rst = 1'b1; refresh_in = 1'b1; #1;
        check("R8 spk low in reset", {7'd0, spk_out}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 cleared, no edge from held refresh", rd_data, 8'h20);
        refresh_in = 1'b0; tone_in = 1'b0;
        @(negedge clk);
        refresh_pulse(1);
        check("R8/R5 first real edge", {7'd0, rd_data[4]}, 8'h01);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule